// File: doc/BRIEF.md
# Host Shared-Memory Window and Mailbox

This block sits between a 16-bit host bus and a coprocessor's private resources. It decodes each 24-bit host byte address and routes the access. One window reaches a shared DRAM as a flat array of words. Two more windows reach the same DRAM through fixed bit permutations of the word address, so the host can walk tile-ordered graphics data with a plain incrementing pointer. A 16-byte register page holds a small mailbox.

The mailbox has two parts. The first is a state word that both sides can write. The second is a two-bit status word that records which side wrote the state word last, and that is cleared when the other side reads it. The host side issues one request per cycle and receives read data with a valid strobe one cycle later. The coprocessor side sees the state word and the status word combinationally, and it has a write strobe and a read strobe. The DRAM port drives a synchronous single-port RAM with one cycle of read latency.

Top module: `host_window_mbox`

## Requirements
- R1: After reset the state word is 0x0000, the status word is 0x0000 and `host_rvalid` is low.
- R2: A host access whose address matches 0x300000 under mask 0xFE0000 reaches DRAM word index addr[16:1]. For a read, `host_rvalid` is high and `host_rdata` holds the word in the cycle after the request. Address bit 0 is ignored everywhere.
- R3: In the range 0x390000–0x39FFFF, with w = addr>>1, the DRAM index has bit 0 = w[0], bits 6..1 = w[11:6], bits 11..7 = w[5:1], bits 14..12 = w[14:12] and bit 15 = 0. This holds for both reads and writes.
- R4: In the range 0x3A0000–0x3AFFFF, with w = addr>>1, the DRAM index has bit 0 = w[0], bits 6..1 = w[10:5], bits 10..7 = w[4:1], bits 14..11 = w[14:11] and bit 15 = 0. This holds for both reads and writes.
- R5: On the register page 0xA15000–0xA1500F, host reads at byte offsets 0 and 2 return the state word. A read at offset 4 returns the status word, with bit 0 = the coprocessor wrote the state word and bit 1 = the host wrote the state word; the other bits read 0. Reads at every other offset return 0.
- R6: A host read of the status word returns the value held before the read, then clears status bit 0.
- R7: A host write to offset 0 or 2 loads the state word and sets status bit 1. Host writes to other offsets of the page change neither word.
- R8: A coprocessor write (`cp_xst_we`) loads the state word and sets status bit 0.
- R9: A coprocessor status read (`cp_stat_re`) clears status bit 1.
- R10: When a set and a read-clear of the same status bit fall in one cycle, the bit ends up set.
- R11: Host reads of unmapped addresses return 0. Host accesses to unmapped addresses raise no DRAM strobe and change no register.
- R12: When the host and the coprocessor write the state word in the same cycle, the host data is stored and both status bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, one per cycle |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 24 | Host byte address |
| host_wdata | input | 16 | Host write data |
| host_rvalid | output | 1 | Read data valid, one cycle after a read request |
| host_rdata | output | 16 | Host read data |
| cp_xst_we | input | 1 | Coprocessor write strobe for the state word |
| cp_xst_wdata | input | 16 | Coprocessor state word data |
| cp_xst_rdata | output | 16 | Current state word |
| cp_stat_re | input | 1 | Coprocessor status read strobe (clears bit 1) |
| cp_stat_rdata | output | 16 | Current status word |
| dram_en | output | 1 | DRAM access strobe |
| dram_we | output | 1 | DRAM write enable |
| dram_addr | output | 16 | DRAM word index |
| dram_wdata | output | 16 | DRAM write data |
| dram_rdata | input | 16 | DRAM read data, one cycle after `dram_en` |

## Verification
The hardest cases to reach are the collisions, where one status bit is set and read-cleared in the same clock by opposite sides, or where both sides write the state word at once. Two separate drivers would line these up only by chance. The bench therefore drives every cycle through a single task that applies host and coprocessor strobes together, and it places each collision deliberately. To reach the permuted windows, the bench writes a pattern linearly at the index it computes for a tile address, reads that pattern back through the tile address, and then does the same in the reverse direction.

// File: rtl/hwm_pkg.sv
package hwm_pkg;

  typedef enum logic [2:0] {
    WIN_NONE   = 3'd0,
    WIN_LIN    = 3'd1,
    WIN_TILE_A = 3'd2,
    WIN_TILE_B = 3'd3,
    WIN_REGS   = 3'd4
  } win_e;

  typedef enum logic [1:0] {
    RSRC_ZERO = 2'd0,
    RSRC_DRAM = 2'd1,
    RSRC_REG  = 2'd2
  } rsrc_e;

  // word offsets inside the register page (byte offset >> 1)
  localparam logic [2:0] ROFF_XST_A = 3'd0;
  localparam logic [2:0] ROFF_XST_B = 3'd1;
  localparam logic [2:0] ROFF_STAT  = 3'd2;

endpackage

// File: rtl/hwm_rst_sync.sv
module hwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/hwm_tile_map.sv
module hwm_tile_map #(
  parameter int ADDR_W  = 24,
  parameter int IDX_W   = 16,
  parameter int VARIANT = 0
) (
  input  logic [ADDR_W-2:0] word,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [31:0] A_KEEP = 32'h0000_7001;
  localparam logic [31:0] A_UP   = 32'h0000_003E;
  localparam logic [31:0] A_DN   = 32'h0000_0FC0;
  localparam logic [31:0] B_KEEP = 32'h0000_7801;
  localparam logic [31:0] B_UP   = 32'h0000_001E;
  localparam logic [31:0] B_DN   = 32'h0000_07E0;

  logic [31:0] w32;
  assign w32 = 32'(word);

  generate
    if (VARIANT == 0) begin : g_tile_a
      assign idx = IDX_W'((w32 & A_KEEP) | ((w32 & A_UP) << 6) | ((w32 & A_DN) >> 5));
    end else begin : g_tile_b
      assign idx = IDX_W'((w32 & B_KEEP) | ((w32 & B_UP) << 6) | ((w32 & B_DN) >> 4));
    end
  endgenerate
endmodule

// File: rtl/hwm_win_decode.sv
module hwm_win_decode
  import hwm_pkg::*;
#(
  parameter int                ADDR_W      = 24,
  parameter int                IDX_W       = 16,
  parameter logic [ADDR_W-1:0] LIN_BASE    = 24'h30_0000,
  parameter logic [ADDR_W-1:0] LIN_MASK    = 24'hFE_0000,
  parameter logic [7:0]        TILE_A_PAGE = 8'h39,
  parameter logic [7:0]        TILE_B_PAGE = 8'h3A,
  parameter logic [ADDR_W-5:0] REG_PAGE    = 20'hA1500
) (
  input  logic [ADDR_W-1:0] addr,
  output win_e              win,
  output logic [IDX_W-1:0]  idx,
  output logic [2:0]        reg_off
);
  logic [7:0]       page;
  logic [IDX_W-1:0] idx_tile_a;
  logic [IDX_W-1:0] idx_tile_b;
  logic             unused_addr0;

  assign page         = addr[ADDR_W-1 -: 8];
  assign reg_off      = addr[3:1];
  assign unused_addr0 = addr[0];

  hwm_tile_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .VARIANT(0)) u_map_a (
    .word (addr[ADDR_W-1:1]),
    .idx  (idx_tile_a)
  );

  hwm_tile_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .VARIANT(1)) u_map_b (
    .word (addr[ADDR_W-1:1]),
    .idx  (idx_tile_b)
  );

  always_comb begin
    win = WIN_NONE;
    idx = '0;
    if ((addr & LIN_MASK) == LIN_BASE) begin
      win = WIN_LIN;
      idx = addr[IDX_W:1];
    end else if (page == TILE_A_PAGE) begin
      win = WIN_TILE_A;
      idx = idx_tile_a;
    end else if (page == TILE_B_PAGE) begin
      win = WIN_TILE_B;
      idx = idx_tile_b;
    end else if (addr[ADDR_W-1:4] == REG_PAGE) begin
      win = WIN_REGS;
    end
  end
endmodule

// File: rtl/hwm_mbox_regs.sv
module hwm_mbox_regs #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_xst_we,
  input  logic [DW-1:0] h_wdata,
  input  logic          h_stat_re,
  input  logic          cp_xst_we,
  input  logic [DW-1:0] cp_wdata,
  input  logic          cp_stat_re,
  output logic [DW-1:0] xst,
  output logic [1:0]    stat
);
  logic [DW-1:0] xst_q, xst_nxt;
  logic [1:0]    stat_q, stat_nxt;
  logic          xst_en, stat_en;

  // next state: host data wins a write collision; any set beats a read-clear
  always_comb begin
    xst_en   = h_xst_we | cp_xst_we;
    xst_nxt  = h_xst_we ? h_wdata : cp_wdata;

    stat_en  = h_xst_we | cp_xst_we | h_stat_re | cp_stat_re;
    stat_nxt = stat_q;
    if (cp_xst_we)      stat_nxt[0] = 1'b1;
    else if (h_stat_re) stat_nxt[0] = 1'b0;
    if (h_xst_we)        stat_nxt[1] = 1'b1;
    else if (cp_stat_re) stat_nxt[1] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xst_q  <= '0;
      stat_q <= '0;
    end else begin
      if (xst_en)  xst_q  <= xst_nxt;
      if (stat_en) stat_q <= stat_nxt;
    end
  end

  assign xst  = xst_q;
  assign stat = stat_q;
endmodule

// File: rtl/host_window_mbox.sv
module host_window_mbox
  import hwm_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DW     = 16,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic              host_rvalid,
  output logic [DW-1:0]     host_rdata,
  input  logic              cp_xst_we,
  input  logic [DW-1:0]     cp_xst_wdata,
  output logic [DW-1:0]     cp_xst_rdata,
  input  logic              cp_stat_re,
  output logic [DW-1:0]     cp_stat_rdata,
  output logic              dram_en,
  output logic              dram_we,
  output logic [IDX_W-1:0]  dram_addr,
  output logic [DW-1:0]     dram_wdata,
  input  logic [DW-1:0]     dram_rdata
);
  logic             rst_core_n;
  win_e             win;
  logic [IDX_W-1:0] idx;
  logic [2:0]       reg_off;
  logic [DW-1:0]    xst;
  logic [1:0]       stat;
  logic [DW-1:0]    stat_word;

  logic             dram_hit, reg_hit, rd_fire;
  logic             h_xst_we, h_stat_re;

  logic             rvalid_q, rvalid_nxt;
  rsrc_e            rsrc_q, rsrc_nxt;
  logic [DW-1:0]    reg_rdata_q, reg_rdata_nxt;

  hwm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  hwm_win_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_decode (
    .addr    (host_addr),
    .win     (win),
    .idx     (idx),
    .reg_off (reg_off)
  );

  hwm_mbox_regs #(.DW(DW)) u_mbox (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .h_xst_we   (h_xst_we),
    .h_wdata    (host_wdata),
    .h_stat_re  (h_stat_re),
    .cp_xst_we  (cp_xst_we),
    .cp_wdata   (cp_xst_wdata),
    .cp_stat_re (cp_stat_re),
    .xst        (xst),
    .stat       (stat)
  );

  assign stat_word = {{(DW-2){1'b0}}, stat};

  // access steering
  always_comb begin
    dram_hit  = host_req && (win == WIN_LIN || win == WIN_TILE_A || win == WIN_TILE_B);
    reg_hit   = host_req && (win == WIN_REGS);
    rd_fire   = host_req && !host_we;
    h_xst_we  = reg_hit && host_we && (reg_off == ROFF_XST_A || reg_off == ROFF_XST_B);
    h_stat_re = reg_hit && !host_we && (reg_off == ROFF_STAT);
  end

  assign dram_en    = dram_hit;
  assign dram_we    = dram_hit && host_we;
  assign dram_addr  = idx;
  assign dram_wdata = host_wdata;

  // read return path: next state
  always_comb begin
    rvalid_nxt    = rd_fire;
    rsrc_nxt      = RSRC_ZERO;
    reg_rdata_nxt = '0;
    if (dram_hit) begin
      rsrc_nxt = RSRC_DRAM;
    end else if (reg_hit) begin
      rsrc_nxt = RSRC_REG;
      unique case (reg_off)
        ROFF_XST_A, ROFF_XST_B: reg_rdata_nxt = xst;
        ROFF_STAT:              reg_rdata_nxt = stat_word;
        default:                reg_rdata_nxt = '0;
      endcase
    end
  end

  // read return path: registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rvalid_q    <= 1'b0;
      rsrc_q      <= RSRC_ZERO;
      reg_rdata_q <= '0;
    end else begin
      rvalid_q <= rvalid_nxt;
      if (rd_fire) begin
        rsrc_q      <= rsrc_nxt;
        reg_rdata_q <= reg_rdata_nxt;
      end
    end
  end

  always_comb begin
    unique case (rsrc_q)
      RSRC_DRAM: host_rdata = dram_rdata;
      RSRC_REG:  host_rdata = reg_rdata_q;
      default:   host_rdata = '0;
    endcase
  end

  assign host_rvalid   = rvalid_q;
  assign cp_xst_rdata  = xst;
  assign cp_stat_rdata = stat_word;
endmodule

// File: rtl/host_window_mbox_chk.sv
module host_window_mbox_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_req,
  input logic        host_we,
  input logic [23:0] host_addr,
  input logic [15:0] host_wdata,
  input logic        host_rvalid,
  input logic [15:0] host_rdata,
  input logic        cp_xst_we,
  input logic        cp_stat_re,
  input logic [15:0] cp_xst_rdata,
  input logic [15:0] cp_stat_rdata,
  input logic        dram_en,
  input logic [15:0] dram_addr
);
  logic page_hit, lin_hit, rom_hit;
  assign page_hit = host_addr[23:4] == 20'hA1500;
  assign lin_hit  = host_addr[23:17] == 7'b0011000;
  assign rom_hit  = host_addr[23:21] == 3'b000;

  AST_RESET_STATE: assert property (@(posedge clk)
    $rose(rst_n) |-> (cp_xst_rdata == 16'h0 && cp_stat_rdata == 16'h0 && !host_rvalid)); // R1

  AST_LIN_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && lin_hit) |-> (dram_en && dram_addr == host_addr[16:1])); // R2

  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we) |=> host_rvalid); // R2

  AST_HOST_XST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && page_hit && host_addr[3:2] == 2'b00)
      |=> (cp_xst_rdata == $past(host_wdata) && cp_stat_rdata[1])); // R7

  AST_CP_SETS_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    cp_xst_we |=> cp_stat_rdata[0]); // R8

  AST_CP_CLEARS_BIT1: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_stat_re && !(host_req && host_we && page_hit && host_addr[3:2] == 2'b00))
      |=> !cp_stat_rdata[1]); // R9

  AST_HOST_CLEARS_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we && page_hit && host_addr[3:1] == 3'd2 && !cp_xst_we)
      |=> !cp_stat_rdata[0]); // R6

  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && rom_hit) |-> !dram_en); // R11

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we && rom_hit) |=> (host_rdata == 16'h0)); // R11
endmodule

bind host_window_mbox host_window_mbox_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_core_n),
  .host_req      (host_req),
  .host_we       (host_we),
  .host_addr     (host_addr),
  .host_wdata    (host_wdata),
  .host_rvalid   (host_rvalid),
  .host_rdata    (host_rdata),
  .cp_xst_we     (cp_xst_we),
  .cp_stat_re    (cp_stat_re),
  .cp_xst_rdata  (cp_xst_rdata),
  .cp_stat_rdata (cp_stat_rdata),
  .dram_en       (dram_en),
  .dram_addr     (dram_addr)
);

// File: tb/host_window_mbox_tb.sv
module host_window_mbox_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [23:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        host_rvalid;
  logic [15:0] host_rdata;
  logic        cp_xst_we = 1'b0;
  logic [15:0] cp_xst_wdata = '0;
  logic [15:0] cp_xst_rdata;
  logic        cp_stat_re = 1'b0;
  logic [15:0] cp_stat_rdata;
  logic        dram_en, dram_we;
  logic [15:0] dram_addr, dram_wdata;
  logic [15:0] dram_rdata = '0;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  host_window_mbox u_dut (.*);

  // sparse synchronous RAM model
  logic [15:0] mem [int];
  always @(posedge clk) begin
    if (dram_en) begin
      if (dram_we) mem[int'(dram_addr)] = dram_wdata;
      else dram_rdata <= mem.exists(int'(dram_addr)) ? mem[int'(dram_addr)] : 16'h0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected rvalid", host_rdata, 16'h0);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(host_rdata == e, t, host_rdata, e);
      end
    end
  end

  // one cycle with host and coprocessor stimulus applied together
  task automatic cyc(input logic req, input logic we, input logic [23:0] a, input logic [15:0] wd,
                     input logic cw, input logic [15:0] cwd, input logic cr,
                     input logic [15:0] exp, input string tag, input bit no_dram);
    host_req = req; host_we = we; host_addr = a; host_wdata = wd;
    cp_xst_we = cw; cp_xst_wdata = cwd; cp_stat_re = cr;
    if (req && !we) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    #1;
    if (no_dram) chk(dram_en == 1'b0, "R11 no DRAM strobe", {15'h0, dram_en}, 16'h0);
    @(posedge clk);
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0; cp_xst_we = 1'b0; cp_stat_re = 1'b0;
  endtask

  task automatic hrd(input logic [23:0] a, input logic [15:0] exp, input string tag);
    cyc(1'b1, 1'b0, a, 16'h0, 1'b0, 16'h0, 1'b0, exp, tag, 1'b0);
  endtask
  task automatic hwr(input logic [23:0] a, input logic [15:0] d);
    cyc(1'b1, 1'b1, a, d, 1'b0, 16'h0, 1'b0, 16'h0, "", 1'b0);
  endtask

  function automatic logic [15:0] idx_a(input logic [23:0] a);
    logic [22:0] w;
    w = a[23:1];
    return {1'b0, w[14:12], w[5:1], w[11:6], w[0]};
  endfunction
  function automatic logic [15:0] idx_b(input logic [23:0] a);
    logic [22:0] w;
    w = a[23:1];
    return {1'b0, w[14:11], w[4:1], w[10:5], w[0]};
  endfunction
  function automatic logic [23:0] lin(input logic [15:0] i);
    return 24'h30_0000 + {7'h0, i, 1'b0};
  endfunction

  logic [23:0] ta [4] = '{24'h39_0042, 24'h39_ABCE, 24'h39_FFFE, 24'h39_1F7C};
  logic [23:0] tb [4] = '{24'h3A_0022, 24'h3A_5E5A, 24'h3A_FFFE, 24'h3A_07C0};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(cp_xst_rdata == 16'h0, "R1 state word after reset", cp_xst_rdata, 16'h0);
    chk(cp_stat_rdata == 16'h0, "R1 status after reset", cp_stat_rdata, 16'h0);
    chk(host_rvalid == 1'b0, "R1 rvalid after reset", {15'h0, host_rvalid}, 16'h0);
    hrd(24'hA1_5004, 16'h0000, "R1 status read after reset");

    // R2 linear window, both halves, back-to-back reads
    hwr(24'h30_0010, 16'h1234);
    hwr(24'h31_FFFE, 16'hBEEF);
    hwr(24'h30_0011, 16'h4321);   // bit 0 ignored: same word as 0x300010
    hrd(24'h30_0010, 16'h4321, "R2 linear low half");
    hrd(24'h31_FFFE, 16'hBEEF, "R2 linear top word");

    // R3 tile window A: linear write -> tile read, tile write -> linear read
    foreach (ta[i]) begin
      hwr(lin(idx_a(ta[i])), idx_a(ta[i]) ^ 16'hC3C3);
      hrd(ta[i], idx_a(ta[i]) ^ 16'hC3C3, "R3 tile A read");
    end
    foreach (ta[i]) begin
      hwr(ta[i], idx_a(ta[i]) ^ 16'h0F0F);
      hrd(lin(idx_a(ta[i])), idx_a(ta[i]) ^ 16'h0F0F, "R3 tile A write");
    end

    // R4 tile window B
    foreach (tb[i]) begin
      hwr(lin(idx_b(tb[i])), idx_b(tb[i]) ^ 16'h5AA5);
      hrd(tb[i], idx_b(tb[i]) ^ 16'h5AA5, "R4 tile B read");
    end
    foreach (tb[i]) begin
      hwr(tb[i], idx_b(tb[i]) ^ 16'h7E7E);
      hrd(lin(idx_b(tb[i])), idx_b(tb[i]) ^ 16'h7E7E, "R4 tile B write");
    end

    // R5 / R7 register page
    hwr(24'hA1_5000, 16'h5A5A);
    chk(cp_xst_rdata == 16'h5A5A, "R7 host write offset 0", cp_xst_rdata, 16'h5A5A);
    chk(cp_stat_rdata == 16'h0002, "R7 host write sets bit1", cp_stat_rdata, 16'h0002);
    hwr(24'hA1_5002, 16'h6B6B);
    chk(cp_xst_rdata == 16'h6B6B, "R7 host write offset 2", cp_xst_rdata, 16'h6B6B);
    hrd(24'hA1_5000, 16'h6B6B, "R5 read offset 0");
    hrd(24'hA1_5002, 16'h6B6B, "R5 read offset 2");
    hrd(24'hA1_5008, 16'h0000, "R5 read other offset");
    hwr(24'hA1_5006, 16'hFFFF);
    chk(cp_xst_rdata == 16'h6B6B, "R7 other offset write ignored", cp_xst_rdata, 16'h6B6B);
    chk(cp_stat_rdata == 16'h0002, "R7 other offset write status", cp_stat_rdata, 16'h0002);

    // R8 then R6
    cyc(1'b0, 1'b0, 24'h0, 16'h0, 1'b1, 16'h1111, 1'b0, 16'h0, "", 1'b0);
    chk(cp_xst_rdata == 16'h1111, "R8 cp write loads state", cp_xst_rdata, 16'h1111);
    chk(cp_stat_rdata == 16'h0003, "R8 cp write sets bit0", cp_stat_rdata, 16'h0003);
    hrd(24'hA1_5004, 16'h0003, "R6 status read returns old value");
    chk(cp_stat_rdata == 16'h0002, "R6 host read clears bit0", cp_stat_rdata, 16'h0002);
    hrd(24'hA1_5004, 16'h0002, "R6 second status read");

    // R9
    cyc(1'b0, 1'b0, 24'h0, 16'h0, 1'b0, 16'h0, 1'b1, 16'h0, "", 1'b0);
    chk(cp_stat_rdata == 16'h0000, "R9 cp read clears bit1", cp_stat_rdata, 16'h0000);

    // R10 collisions: bit0 set with host read-clear; bit1 set with cp read-clear
    cyc(1'b1, 1'b0, 24'hA1_5004, 16'h0, 1'b1, 16'h2222, 1'b0, 16'h0000, "R10 read during cp write", 1'b0);
    chk(cp_stat_rdata[0] == 1'b1, "R10 bit0 set beats clear", cp_stat_rdata, 16'h0001);
    cyc(1'b1, 1'b1, 24'hA1_5000, 16'h3333, 1'b0, 16'h0, 1'b1, 16'h0, "", 1'b0);
    chk(cp_stat_rdata == 16'h0003, "R10 bit1 set beats clear", cp_stat_rdata, 16'h0003);

    // R12 simultaneous writes
    cyc(1'b0, 1'b0, 24'h0, 16'h0, 1'b0, 16'h0, 1'b1, 16'h0, "", 1'b0);
    hrd(24'hA1_5004, 16'h0001, "R9 status after cp read");
    cyc(1'b1, 1'b1, 24'hA1_5002, 16'hAAAA, 1'b1, 16'h5555, 1'b0, 16'h0, "", 1'b0);
    chk(cp_xst_rdata == 16'hAAAA, "R12 host data wins", cp_xst_rdata, 16'hAAAA);
    chk(cp_stat_rdata == 16'h0003, "R12 both bits set", cp_stat_rdata, 16'h0003);

    // R11 unmapped
    cyc(1'b1, 1'b0, 24'h00_0100, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0000, "R11 unmapped read low", 1'b1);
    cyc(1'b1, 1'b0, 24'h32_0000, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0000, "R11 unmapped read gap", 1'b1);
    cyc(1'b1, 1'b0, 24'hA1_5010, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0000, "R11 read past page", 1'b1);
    cyc(1'b1, 1'b1, 24'h20_0010, 16'hDEAD, 1'b0, 16'h0, 1'b0, 16'h0, "", 1'b1);
    cyc(1'b1, 1'b1, 24'hA1_4000, 16'hDEAD, 1'b0, 16'h0, 1'b0, 16'h0, "", 1'b1);
    chk(cp_xst_rdata == 16'hAAAA, "R11 unmapped write keeps state", cp_xst_rdata, 16'hAAAA);
    chk(cp_stat_rdata == 16'h0003, "R11 unmapped write keeps status", cp_stat_rdata, 16'h0003);
    hrd(24'h30_0010, 16'h4321, "R11 DRAM untouched");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all reads returned", 16'(exp_q.size()), 16'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R2 actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule